// File: doc/BRIEF.md
# Discrete Cartridge Bank-Switch Mapper

This block is the bank-switching logic of a cartridge built from plain latches and gates. It watches the CPU bus for write cycles to its decoded range and captures one bank-select byte. From that byte it extends the address of a 32 KB program ROM window seen by the CPU and of an 8 KB pattern ROM window seen by the video processor. The video RAM page line (A10 of the nametable RAM) comes from a strap that picks horizontal or vertical mirroring and never changes at run time.

In the default build the register covers the whole upper half of CPU space, which is where the program ROM also answers. A write there therefore meets the ROM's own output on the data bus, and the latched byte is the AND of the two. A build parameter instead moves the register to the $6000-$7FFF window, where no ROM drives the bus. The same parameter set picks how many PRG and CHR bank bits are kept. Two bits each is the standard board, one PRG bit is the 64 KB board, and four bits each is the oversize form.

Capture is run by a two-state write machine. IDLE waits for a decoded write. The transition IDLE to ARMED happens on a clock edge that sees the strobe high during such a write, and the register loads on that same edge. ARMED waits for the strobe to fall. The transition ARMED to IDLE happens on the first edge that sees the strobe low. A single strobe pulse therefore loads the register only once.

Top module: `discrete_bank_mapper`

## Requirements
- R1: On reset both bank fields are 0, so `prg_rom_addr` equals {0, cpu_addr[14:0]} and `chr_rom_addr` equals {0, ppu_addr[12:0]}.
- R2: A write (cpu_rw=0, cpu_strobe=1) to the decoded range, seen in IDLE at a clock edge, loads the register. The new banks appear on the outputs after that edge.
- R3: `prg_rom_addr` is {bank byte bits [4 +: PRG_BANK_BITS], cpu_addr[14:0]}. With the standard 2 bits, byte bits 5:4 form the top address bits.
- R4: `chr_rom_addr` is {bank byte bits [0 +: CHR_BANK_BITS], ppu_addr[12:0]}. With the standard 2 bits, byte bits 1:0 form the top address bits.
- R5: With standard widths, byte bits 7:6 and 3:2 have no effect on either output.
- R6: With the register in the upper half (cpu_romsel_n=0, cpu_addr[15]=1), the loaded byte is cpu_data AND rom_data.
- R7: Read cycles (cpu_rw=1) never change the register.
- R8: With REG_AT_6000=1, only writes to $6000-$7FFF (cpu_romsel_n=1, cpu_addr[15:13]=3'b011) load the register, taking cpu_data unmasked. Writes to $8000-$FFFF have no effect.
- R9: `nt_a10` equals ppu_addr[10] when mirror_strap=1 (vertical) and ppu_addr[11] when mirror_strap=0 (horizontal).
- R10: While ARMED (the strobe is still high after a load), changes on cpu_data are not loaded. The next load needs the strobe to go low first.
- R11: With PRG_BANK_BITS=1 (64 KB board), byte bit 5 is ignored and only bit 4 selects the PRG bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Mapper clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_romsel_n | input | 1 | Low while the CPU addresses $8000-$FFFF |
| cpu_strobe | input | 1 | High during the data phase of a CPU cycle |
| rom_data | input | 8 | Byte the program ROM drives at cpu_addr |
| ppu_addr | input | 13 | Video pattern address |
| mirror_strap | input | 1 | 1 = vertical, 0 = horizontal mirroring |
| prg_rom_addr | output | 15+PRG_BANK_BITS | Extended program ROM address |
| chr_rom_addr | output | 13+CHR_BANK_BITS | Extended pattern ROM address |
| nt_a10 | output | 1 | Nametable RAM page line |

## Verification
The hardest situations to reach from the ports are the bus-conflict AND and the held strobe. In both, the byte that ends up latched differs from the byte the CPU put on the bus. The bench sweeps every CPU data value against varied ROM bytes and predicts the AND for each one. It also holds the strobe high across a data change to show that only the first byte lands. A second instance with the $6000 register and a one-bit PRG field shares the same bus, so each write also checks that the other decode ignores it.

// File: rtl/gx_mapper_pkg.sv
package gx_mapper_pkg;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_ARMED = 1'b1
    } wr_state_t;

    localparam int BANK_BYTE_W = 8;
    localparam int PRG_FIELD_LSB = 4;
    localparam int CHR_FIELD_LSB = 0;

endpackage

// File: rtl/gx_addr_decode.sv
module gx_addr_decode #(
    parameter bit REG_AT_6000 = 1'b0
) (
    input  logic [2:0] addr_top,
    input  logic       romsel_n,
    input  logic       rw,
    output logic       wr_hit,
    output logic       conflict
);

    logic hit_upper;
    logic hit_low;

    assign hit_upper = !romsel_n && addr_top[2];
    assign hit_low   = romsel_n && (addr_top == 3'b011);

    generate
        if (REG_AT_6000) begin : g_low_window
            assign wr_hit   = !rw && hit_low;
            assign conflict = 1'b0;
        end else begin : g_upper_window
            assign wr_hit   = !rw && hit_upper;
            assign conflict = 1'b1;
        end
    endgenerate

    logic unused_hits;
    assign unused_hits = hit_upper ^ hit_low;

endmodule

// File: rtl/gx_bank_fsm.sv
module gx_bank_fsm
    import gx_mapper_pkg::*;
#(
    parameter int PRG_BITS = 2,
    parameter int CHR_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic                wr_hit,
    input  logic                conflict,
    input  logic [7:0]          cpu_data,
    input  logic [7:0]          rom_data,
    output logic [PRG_BITS-1:0] prg_bank,
    output logic [CHR_BITS-1:0] chr_bank
);

    wr_state_t state_q, state_d;
    logic      take;
    logic [BANK_BYTE_W-1:0] load_val;

    assign take     = (state_q == S_IDLE) && strobe && wr_hit;
    assign load_val = conflict ? (cpu_data & rom_data) : cpu_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (take)    state_d = S_ARMED;
            S_ARMED: if (!strobe) state_d = S_IDLE;
            default:              state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prg_bank <= '0;
            chr_bank <= '0;
        end else if (take) begin
            prg_bank <= load_val[PRG_FIELD_LSB +: PRG_BITS];
            chr_bank <= load_val[CHR_FIELD_LSB +: CHR_BITS];
        end
    end

    logic unused_load;
    assign unused_load = ^load_val;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (prg_bank == '0 && chr_bank == '0));

    p_conflict_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && conflict) |=>
            (chr_bank == $past(cpu_data[CHR_FIELD_LSB +: CHR_BITS] & rom_data[CHR_FIELD_LSB +: CHR_BITS]))
         && (prg_bank == $past(cpu_data[PRG_FIELD_LSB +: PRG_BITS] & rom_data[PRG_FIELD_LSB +: PRG_BITS])));

    p_no_hit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(prg_bank) && $stable(chr_bank)));

    p_armed_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED) |=> ($stable(prg_bank) && $stable(chr_bank)));

endmodule

// File: rtl/gx_nt_mirror.sv
module gx_nt_mirror (
    input  logic [1:0] page_bits,
    input  logic       vertical,
    output logic       nt_a10
);

    assign nt_a10 = vertical ? page_bits[0] : page_bits[1];

endmodule

// File: rtl/discrete_bank_mapper.sv
module discrete_bank_mapper #(
    parameter bit REG_AT_6000   = 1'b0,
    parameter int PRG_BANK_BITS = 2,
    parameter int CHR_BANK_BITS = 2,
    localparam int PRG_ADDR_W   = 15 + PRG_BANK_BITS,
    localparam int CHR_ADDR_W   = 13 + CHR_BANK_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           cpu_addr,
    input  logic [7:0]            cpu_data,
    input  logic                  cpu_rw,
    input  logic                  cpu_romsel_n,
    input  logic                  cpu_strobe,
    input  logic [7:0]            rom_data,
    input  logic [12:0]           ppu_addr,
    input  logic                  mirror_strap,
    output logic [PRG_ADDR_W-1:0] prg_rom_addr,
    output logic [CHR_ADDR_W-1:0] chr_rom_addr,
    output logic                  nt_a10
);

    logic wr_hit;
    logic conflict;
    logic [PRG_BANK_BITS-1:0] prg_bank;
    logic [CHR_BANK_BITS-1:0] chr_bank;

    gx_addr_decode #(.REG_AT_6000(REG_AT_6000)) u_decode (
        .addr_top (cpu_addr[15:13]),
        .romsel_n (cpu_romsel_n),
        .rw       (cpu_rw),
        .wr_hit   (wr_hit),
        .conflict (conflict)
    );

    gx_bank_fsm #(.PRG_BITS(PRG_BANK_BITS), .CHR_BITS(CHR_BANK_BITS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (cpu_strobe),
        .wr_hit   (wr_hit),
        .conflict (conflict),
        .cpu_data (cpu_data),
        .rom_data (rom_data),
        .prg_bank (prg_bank),
        .chr_bank (chr_bank)
    );

    gx_nt_mirror u_mirror (
        .page_bits (ppu_addr[11:10]),
        .vertical  (mirror_strap),
        .nt_a10    (nt_a10)
    );

    assign prg_rom_addr = {prg_bank, cpu_addr[14:0]};
    assign chr_rom_addr = {chr_bank, ppu_addr};

endmodule

// File: tb/discrete_bank_mapper_bench.sv
`timescale 1ns/1ps
module discrete_bank_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        cpu_romsel_n = 1'b1;
    logic        cpu_strobe = 1'b0;
    logic [7:0]  rom_data = 8'hFF;
    logic [12:0] ppu_addr = 13'h0;
    logic        strap = 1'b0;

    logic [16:0] prg_a;
    logic [14:0] chr_a;
    logic        nt_a;
    logic [15:0] prg_b;
    logic [14:0] chr_b;
    logic        nt_b;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_main = 8'h00;
    logic [7:0] exp_alt  = 8'h00;

    always #2.5 clk = ~clk;

    discrete_bank_mapper u_discrete_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_romsel_n(cpu_romsel_n), .cpu_strobe(cpu_strobe),
        .rom_data(rom_data), .ppu_addr(ppu_addr), .mirror_strap(strap),
        .prg_rom_addr(prg_a), .chr_rom_addr(chr_a), .nt_a10(nt_a)
    );

    discrete_bank_mapper #(.REG_AT_6000(1'b1), .PRG_BANK_BITS(1), .CHR_BANK_BITS(2))
        u_discrete_bank_mapper_alt (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_romsel_n(cpu_romsel_n), .cpu_strobe(cpu_strobe),
        .rom_data(rom_data), .ppu_addr(ppu_addr), .mirror_strap(~strap),
        .prg_rom_addr(prg_b), .chr_rom_addr(chr_b), .nt_a10(nt_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Idle bus, sample both instances at several addresses (R3 R4 R5 R11 R8)
    task automatic check_banks(input string tag);
        logic [15:0] ca [3] = '{16'h8000, 16'hFFFF, 16'hC123};
        logic [12:0] pa [3] = '{13'h0000, 13'h1FFF, 13'h0ABC};
        @(negedge clk);
        cpu_rw = 1'b1; cpu_strobe = 1'b0;
        for (int k = 0; k < 3; k++) begin
            cpu_addr = ca[k]; cpu_romsel_n = ~ca[k][15]; ppu_addr = pa[k];
            #0.3;
            chk({tag, " R3 prg"}, 32'(prg_a), 32'({exp_main[5:4], ca[k][14:0]}));
            chk({tag, " R4 chr"}, 32'(chr_a), 32'({exp_main[1:0], pa[k]}));
            chk({tag, " R11 prg alt"}, 32'(prg_b), 32'({exp_alt[4], ca[k][14:0]}));
            chk({tag, " R8 chr alt"}, 32'(chr_b), 32'({exp_alt[1:0], pa[k]}));
        end
    endtask

    task automatic write_cycle(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r);
        @(negedge clk);
        cpu_addr = a; cpu_romsel_n = ~a[15]; cpu_data = d; rom_data = r;
        cpu_rw = 1'b0; cpu_strobe = 1'b1;
        @(negedge clk);
        cpu_strobe = 1'b0; cpu_rw = 1'b1;
        if (a[15]) exp_main = d & r;
        else if (a[15:13] == 3'b011) exp_alt = d;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_banks("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_banks("R1 after release");

        // R2 R5: every byte, no conflict (ROM reads FF)
        for (int i = 0; i < 256; i++) begin
            write_cycle(16'h8000 | 16'(i * 97), 8'(i), 8'hFF);
            check_banks("R2 R5 sweep");
        end

        // R6: bus conflict AND
        for (int i = 0; i < 256; i++) begin
            write_cycle(16'hA000 | 16'(i), 8'(i), 8'(~(i * 37 + 5)));
            check_banks("R6 conflict");
        end

        // R8: $6000 window loads alt only, unmasked
        for (int i = 0; i < 256; i++) begin
            write_cycle(16'h6000 | 16'(i * 31), 8'(255 - i), 8'(i * 3));
            check_banks("R8 low window");
        end

        // R8: writes outside both windows ignored
        write_cycle(16'h4020, 8'hFF, 8'hFF);
        check_banks("R8 outside");

        // R7: read cycles with strobe do not load
        write_cycle(16'h8000, 8'h12, 8'hFF);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cpu_addr = 16'h8000 | 16'(i << 12); cpu_romsel_n = ~cpu_addr[15];
            cpu_data = 8'(~i); rom_data = 8'hFF; cpu_rw = 1'b1; cpu_strobe = 1'b1;
            @(negedge clk);
            cpu_strobe = 1'b0;
            check_banks("R7 read");
        end

        // R10: strobe held across a data change
        @(negedge clk);
        cpu_addr = 16'h9000; cpu_romsel_n = 1'b0; rom_data = 8'hFF;
        cpu_data = 8'h21; cpu_rw = 1'b0; cpu_strobe = 1'b1;
        @(negedge clk);
        cpu_data = 8'h12;
        @(negedge clk);
        cpu_data = 8'h33;
        @(negedge clk);
        cpu_strobe = 1'b0; cpu_rw = 1'b1;
        exp_main = 8'h21;
        check_banks("R10 held strobe");
        write_cycle(16'h9000, 8'h33, 8'hFF);
        check_banks("R10 next pulse");

        // R9: mirroring, both straps, full pattern range
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            for (int p = 0; p < 8192; p++) begin
                ppu_addr = 13'(p);
                #0.1;
                chk("R9 nt main", 32'(nt_a), 32'(s[0] ? ppu_addr[10] : ppu_addr[11]));
                chk("R9 nt alt", 32'(nt_b), 32'(s[0] ? ppu_addr[11] : ppu_addr[10]));
            end
        end

        // R1: reset mid-run
        write_cycle(16'h8000, 8'h33, 8'hFF);
        write_cycle(16'h6000, 8'h33, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        exp_main = 8'h00; exp_alt = 8'h00;
        check_banks("R1 mid reset");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule